// File: doc/BRIEF.md
# GPIO Event and Interrupt Detector

This block watches a 32-bit word of sampled pin data and records events on it, one pin per bit. A per-pin trigger-mode bit picks one of two kinds of trigger. In level mode a pin that reads high raises its event. In edge mode a pin raises its event when it changes to high, or on any change when the pin's dual-edge bit is also set. The data word and a change mask that marks which pins moved this cycle come from the input-sampling stage.

Captured events set sticky bits in a status register. Software clears those bits by writing ones to them. An enable register selects which status bits reach the single interrupt line. Software can write the enable register as a whole, or set and clear bits in it through two separate write codes. The interrupt line is registered and follows the OR of the enabled status bits one cycle later.

Top module: `gpio_evt_det`

## Requirements
- R1: A pin in level mode (trigger-mode bit 0) whose data bit is 1 in a cycle has its status bit set at the next clock edge, with or without a change-mask bit.
- R2: A pin in edge mode (trigger-mode bit 1) with its dual-edge bit 1 has its status bit set at the next edge whenever its change-mask bit is 1, whatever its data bit is.
- R3: A pin in edge mode has its status bit set when its change-mask bit and data bit are both 1, whatever its dual-edge bit is. With the dual-edge bit 0, a change to 0 sets nothing.
- R4: irq_o is a register. It rises one edge after any bit of (status AND enable) becomes 1 and falls one edge after no such bit remains. A status bit that is not enabled never raises irq_o.
- R5: A write with code 5 clears every status bit whose data bit is 1 and leaves the status bits whose data bit is 0 unchanged.
- R6: Status bits are sticky. A set bit stays set after its trigger goes away, until a code-5 write clears it.
- R7: When a code-5 clear and a new trigger hit the same bit in the same cycle, the trigger wins and the bit stays set.
- R8: Write code 2 loads the enable register. Code 3 ORs the data into it. Code 4 clears the enable bits whose data bit is 1.
- R9: Write code 0 loads the trigger-mode register and code 1 loads the dual-edge register. The new values take effect from the next cycle.
- R10: After reset the status, enable, trigger-mode and dual-edge registers and irq_o are all zero.
- R11: Write codes 6 and 7 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| din_i | input | 32 | Sampled pin data word |
| chg_i | input | 32 | Per-pin mask of data bits that changed this cycle |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Write code: 0 mode, 1 dual-edge, 2 enable, 3 enable set, 4 enable clear, 5 status clear |
| wr_data_i | input | 32 | Write data |
| status_o | output | 32 | Sticky event status |
| en_o | output | 32 | Interrupt enable register |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench targets the cases where a detector most often picks the wrong event. A falling edge with dual-edge off must set nothing; a detector that fired on any change would set the bit. A level pin held high during its own clear must stay set; a design that let the clear win would drop a live event. Mixed words put level, rising-only and dual-edge pins next to each other, so a mixed-up mode decode shows up as wrong bits. The one-cycle lag of irq_o is checked on both edges, and so are masked status bits and unused write codes, which must leave every visible register as it was.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;
  typedef enum logic [2:0] {
    SEL_MODE     = 3'd0,
    SEL_DUAL     = 3'd1,
    SEL_EN       = 3'd2,
    SEL_EN_SET   = 3'd3,
    SEL_EN_CLR   = 3'd4,
    SEL_STAT_W1C = 3'd5
  } wsel_e;
endpackage

// File: rtl/evt_cfg.sv
module evt_cfg
  import gpio_evt_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [2:0]   wr_sel_i,
  input  logic [N-1:0] wr_data_i,
  output logic [N-1:0] mode_o,
  output logic [N-1:0] dual_o,
  output logic [N-1:0] en_o,
  output logic [N-1:0] clr_o
);
  wsel_e sel;
  assign sel = wsel_e'(wr_sel_i);

  logic [N-1:0] mode_q, dual_q, en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      dual_q <= '0;
      en_q   <= '0;
    end else if (wr_en_i) begin
      case (sel)
        SEL_MODE:   mode_q <= wr_data_i;
        SEL_DUAL:   dual_q <= wr_data_i;
        SEL_EN:     en_q   <= wr_data_i;
        SEL_EN_SET: en_q   <= en_q | wr_data_i;
        SEL_EN_CLR: en_q   <= en_q & ~wr_data_i;
        default: ;
      endcase
    end
  end

  assign clr_o  = (wr_en_i && sel == SEL_STAT_W1C) ? wr_data_i : '0;
  assign mode_o = mode_q;
  assign dual_o = dual_q;
  assign en_o   = en_q;

  p_en_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == 3'd3) |=> ((en_q & $past(wr_data_i)) == $past(wr_data_i)));
  p_en_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == 3'd4) |=> ((en_q & $past(wr_data_i)) == '0));
  p_unused_code_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i[2:1] == 2'b11) |=> ($stable(en_q) && $stable(mode_q) && $stable(dual_q)));
endmodule

// File: rtl/evt_trig.sv
module evt_trig #(
  parameter int unsigned N = 32
) (
  input  logic [N-1:0] din_i,
  input  logic [N-1:0] chg_i,
  input  logic [N-1:0] mode_i,
  input  logic [N-1:0] dual_i,
  output logic [N-1:0] trig_o
);
  for (genvar i = 0; i < N; i++) begin : g_pin
    logic lvl_hit, edge_hit;
    assign lvl_hit  = !mode_i[i] && din_i[i];
    // edge mode: rising always, falling only with dual-edge
    assign edge_hit = mode_i[i] && chg_i[i] && (din_i[i] || dual_i[i]);
    assign trig_o[i] = lvl_hit || edge_hit;
  end
endmodule

// File: rtl/evt_status.sv
module evt_status #(
  parameter int unsigned N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] trig_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] status_o,
  output logic         irq_o
);
  logic [N-1:0] status_q;
  logic         irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= (status_q & ~clr_i) | trig_i;  // new event beats clear
      irq_q    <= |(status_q & en_i);
    end
  end

  assign status_o = status_q;
  assign irq_o    = irq_q;

  p_capture_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_q & $past(trig_i)) == $past(trig_i)));
  p_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(status_q) & ~$past(clr_i) & ~status_q) == '0));
  p_irq_rise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(status_q & en_i)) |=> irq_q);
  p_irq_fall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(|(status_q & en_i))) |=> !irq_q);
endmodule

// File: rtl/gpio_evt_det.sv
module gpio_evt_det #(
  parameter int unsigned N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] din_i,
  input  logic [N-1:0] chg_i,
  input  logic         wr_en_i,
  input  logic [2:0]   wr_sel_i,
  input  logic [N-1:0] wr_data_i,
  output logic [N-1:0] status_o,
  output logic [N-1:0] en_o,
  output logic         irq_o
);
  logic [N-1:0] mode, dual, en, clr, trig;

  evt_cfg #(.N(N)) u_cfg (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i,
    .mode_o(mode), .dual_o(dual), .en_o(en), .clr_o(clr)
  );

  evt_trig #(.N(N)) u_trig (
    .din_i, .chg_i, .mode_i(mode), .dual_i(dual), .trig_o(trig)
  );

  evt_status #(.N(N)) u_stat (
    .clk_i, .rst_ni, .trig_i(trig), .clr_i(clr), .en_i(en),
    .status_o, .irq_o
  );

  assign en_o = en;

  p_level_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_o & $past(din_i & ~mode)) == $past(din_i & ~mode)));
endmodule

// File: tb/tb_gpio_evt_det.sv
module tb_gpio_evt_det;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;
  localparam int NV = 6;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] din = '0, chg = '0, wdata = '0;
  logic wr_en = 0;
  logic [2:0] wsel = '0;
  logic [N-1:0] status, en;
  logic irq;

  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_evt_det #(.N(N)) dut (
    .clk_i(clk), .rst_ni(rst_n), .din_i(din), .chg_i(chg),
    .wr_en_i(wr_en), .wr_sel_i(wsel), .wr_data_i(wdata),
    .status_o(status), .en_o(en), .irq_o(irq)
  );

  // mode, dual, din, chg, expected status
  typedef logic [4*N+N-1:0] vec_t;
  localparam vec_t VT [NV] = '{
    {32'h0000_0000, 32'h0000_0000, 32'h0000_00F0, 32'h0000_0000, 32'h0000_00F0},
    {32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'h0000_00FF, 32'h0000_0000},
    {32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_000A, 32'h0000_000F, 32'h0000_000F},
    {32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_000A, 32'h0000_000F, 32'h0000_000A},
    {32'hFFFF_0000, 32'h00FF_0000, 32'h0F0F_0F0F, 32'hFF00_FF00, 32'h0F00_0F0F},
    {32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000}
  };

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [N-1:0] d);
    @(negedge clk);
    wr_en = 1; wsel = s; wdata = d;
    @(negedge clk);
    wr_en = 0; wdata = '0;
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 status", status, '0);
    chk("R10 en", en, '0);
    chk("R10 irq", {31'b0, irq}, '0);
    rst_n = 1;
    @(negedge clk);

    // R1 R2 R3 R9 vector table
    for (int v = 0; v < NV; v++) begin
      wr(3'd0, VT[v][159:128]);
      wr(3'd1, VT[v][127:96]);
      wr(3'd5, '1);
      din = VT[v][95:64]; chg = VT[v][63:32];
      @(negedge clk);
      din = '0; chg = '0;
      chk($sformatf("R1/R2/R3 vec %0d", v), status, VT[v][31:0]);
    end

    // R4 irq timing; level mode everywhere
    wr(3'd0, '0);
    wr(3'd5, '1);
    @(negedge clk);
    wr(3'd2, 32'h0000_0001);
    chk("R8 full load", en, 32'h0000_0001);
    din = 32'h1;
    @(negedge clk);
    din = '0;
    chk("R1 bit0 set", status, 32'h1);
    chk("R4 irq lags", {31'b0, irq}, '0);
    @(negedge clk);
    chk("R4 irq rise", {31'b0, irq}, 32'h1);
    // R6 sticky
    repeat (3) @(negedge clk);
    chk("R6 sticky", status, 32'h1);
    // R5 zero-data clear does nothing
    wr(3'd5, 32'hFFFF_FFFE);
    chk("R5 zero bits kept", status, 32'h1);
    wr(3'd5, 32'h1);
    chk("R5 cleared", status, '0);
    chk("R4 irq still high", {31'b0, irq}, 32'h1);
    @(negedge clk);
    chk("R4 irq fall", {31'b0, irq}, '0);

    // R4 masked bit
    din = 32'h4;
    @(negedge clk);
    din = '0;
    repeat (2) @(negedge clk);
    chk("R4 masked status", status, 32'h4);
    chk("R4 masked irq", {31'b0, irq}, '0);
    wr(3'd5, '1);

    // R7 clear vs live level trigger
    din = 32'h2;
    @(negedge clk);
    wr(3'd5, 32'h2);
    chk("R7 event wins", status, 32'h2);
    din = '0;
    wr(3'd5, 32'h2);
    chk("R7 clears after", status, '0);

    // R8 aliases
    wr(3'd3, 32'h0000_00F0);
    chk("R8 set alias", en, 32'h0000_00F1);
    wr(3'd4, 32'h0000_0031);
    chk("R8 clear alias", en, 32'h0000_00C0);

    // R11 unused codes
    din = 32'h8;
    @(negedge clk);
    din = '0;
    wr(3'd6, '1);
    wr(3'd7, '1);
    chk("R11 en unchanged", en, 32'h0000_00C0);
    chk("R11 status unchanged", status, 32'h8);
    // R9: mode still level after unused writes
    din = 32'h10;
    @(negedge clk);
    din = '0;
    chk("R9 mode kept", status, 32'h18);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule